// File: doc/BRIEF.md
# Synchronous I2S Transmit Clock Generator and Serializer

This block feeds a stereo audio DAC from one master clock. The master clock goes straight out to the DAC. The bit clock and the word-select (frame) clock are made from it with plain counters, so the ratios between the three clocks are exact integers and the clocks always keep the same phase relationship. No fractional divider and no second synthesizer is involved.

A frame has 48 bit-clock periods, 24 for each channel. Each sample is 24 bits wide and is sent MSB first in I2S timing. One input selects a frame of 768 or 384 master clocks, which is 48 kS/s or 96 kS/s from a 36.864 MHz master clock. The sample source gets a one-cycle request pulse at each frame start. It must place the next left/right pair on the parallel inputs before the following frame start, where the block latches that pair.

Top module: `i2s_tx_clkgen`

## Requirements
- R1: One frame, measured between two successive falling edges of `lrclk_o`, lasts exactly 768 `clk_i` cycles when `rate_sel_i`=0 and exactly 384 cycles when `rate_sel_i`=1.
- R2: `sclk_o` completes exactly 48 periods per frame. Each period is 16 `clk_i` cycles at rate 0 and 8 cycles at rate 1, with equal high and low halves, so it is high for 384 or 192 cycles of the frame.
- R3: Bit-clock slots are numbered 0 to 47 from the `lrclk_o` falling edge. The left sample goes out MSB first in slots 1 to 24. `sdata_o` changes only together with a falling `sclk_o` edge and is stable while `sclk_o` is high.
- R4: The right sample goes out MSB first in slots 25 to 47. Its LSB goes out in slot 0 of the following frame.
- R5: `lrclk_o` is low in slots 0 to 23 (left) and high in slots 24 to 47 (right). It changes only together with a falling `sclk_o` edge.
- R6: `req_o` is high for exactly one cycle, the cycle in which `lrclk_o` falls. The pair on `left_i`/`right_i` at that clock edge is the pair sent in that frame.
- R7: A change of `rate_sel_i` takes effect only at the next frame start. The frame in progress keeps its length.
- R8: Changes on `left_i`/`right_i` between two frame starts do not alter the data being sent.
- R9: While `rst_ni` is low, `sclk_o` and `lrclk_o` are high and `sdata_o` and `req_o` are low. The first rising `clk_i` edge after reset release starts a frame.
- R10: `mclk_o` carries `clk_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 1 | Frame rate: 0 = 768 master clocks per frame, 1 = 384 |
| left_i | input | 24 | Next left sample, two's complement |
| right_i | input | 24 | Next right sample, two's complement |
| req_o | output | 1 | One-cycle request for the next sample pair |
| mclk_o | output | 1 | Master clock to the DAC |
| sclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Word-select clock, low = left |
| sdata_o | output | 1 | Serial data |

## Verification
Two things fall on the same master clock edge at every frame boundary. The right sample's LSB goes out in slot 0, and a new pair, and possibly a new rate, is latched. The bench checks that slot 0 carries the LSB of the previous right sample and not that of the newly latched one. It also changes the sample inputs and the rate select in the middle of a frame, and checks that the running frame keeps its data and its length while the next frame takes up the new values.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef enum logic {
    RATE_BASE   = 1'b0,
    RATE_DOUBLE = 1'b1
  } rate_e;
endpackage

// File: rtl/i2s_bitclk.sv
module i2s_bitclk
  import i2s_tx_pkg::*;
#(
  parameter int HALF_BASE = 8,
  parameter int PH_W      = $clog2(2 * HALF_BASE)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rate_sel_i,
  input  logic frame_start_i,
  output logic slot_adv_o,
  output logic sclk_o
);
  localparam int LAST_BASE = 2 * HALF_BASE - 1;
  localparam int HALF_DBL  = HALF_BASE / 2;
  localparam int LAST_DBL  = HALF_BASE - 1;

  rate_e           rate_q, rate_n;
  logic [PH_W-1:0] ph_q, ph_n, last_cur, half_n;
  logic            sclk_q;

  assign last_cur   = (rate_q == RATE_DOUBLE) ? PH_W'(LAST_DBL) : PH_W'(LAST_BASE);
  assign slot_adv_o = (ph_q == last_cur);
  assign ph_n       = slot_adv_o ? '0 : ph_q + 1'b1;
  // rate is only sampled when a new frame begins
  assign rate_n     = frame_start_i ? rate_e'(rate_sel_i) : rate_q;
  assign half_n     = (rate_n == RATE_DOUBLE) ? PH_W'(HALF_DBL) : PH_W'(HALF_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_W'(LAST_BASE);
      rate_q <= RATE_BASE;
      sclk_q <= 1'b1;
    end else begin
      ph_q   <= ph_n;
      rate_q <= rate_n;
      sclk_q <= (ph_n >= half_n);
    end
  end

  assign sclk_o = sclk_q;

  a_r7_rate_at_frame_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_q != $past(rate_q)) |-> $past(frame_start_i));

  a_r2_phase_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_q == RATE_DOUBLE) |-> (ph_q <= PH_W'(LAST_DBL)));
endmodule

// File: rtl/i2s_frame_seq.sv
module i2s_frame_seq #(
  parameter int SAMPLE_W = 24,
  parameter int SLOTS    = 2 * SAMPLE_W,
  parameter int SLOT_W   = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_adv_i,
  output logic              frame_start_o,
  output logic [SLOT_W-1:0] slot_n_o,
  output logic              lrclk_o,
  output logic              req_o
);
  localparam int LAST_SLOT = SLOTS - 1;

  logic [SLOT_W-1:0] slot_q;
  logic              lr_q, req_q;

  assign frame_start_o = slot_adv_i && (slot_q == SLOT_W'(LAST_SLOT));
  always_comb begin
    slot_n_o = slot_q;
    if (slot_adv_i) slot_n_o = frame_start_o ? '0 : slot_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= SLOT_W'(LAST_SLOT);
      lr_q   <= 1'b1;
      req_q  <= 1'b0;
    end else begin
      slot_q <= slot_n_o;
      lr_q   <= (slot_n_o >= SLOT_W'(SAMPLE_W));
      req_q  <= frame_start_o;
    end
  end

  assign lrclk_o = lr_q;
  assign req_o   = req_q;

  a_r1_slot_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= SLOT_W'(LAST_SLOT));

  a_r6_req_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
endmodule

// File: rtl/i2s_serializer.sv
module i2s_serializer #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = $clog2(2 * SAMPLE_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_start_i,
  input  logic                slot_adv_i,
  input  logic [SLOT_W-1:0]   slot_n_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sdata_o
);
  logic [SAMPLE_W-1:0] l_q, r_q, l_sh, r_sh;
  logic [SLOT_W-1:0]   idx_l, idx_r;
  logic                sd_q, sd_n;

  assign idx_l = SLOT_W'(SAMPLE_W) - slot_n_i;
  assign idx_r = SLOT_W'(2 * SAMPLE_W) - slot_n_i;
  assign l_sh  = l_q >> idx_l;
  assign r_sh  = r_q >> idx_r;

  // slot 0 carries the old right LSB; evaluated before the new pair lands
  always_comb begin
    if (slot_n_i == '0)                        sd_n = r_q[0];
    else if (slot_n_i <= SLOT_W'(SAMPLE_W))    sd_n = l_sh[0];
    else                                       sd_n = r_sh[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_q  <= '0;
      r_q  <= '0;
      sd_q <= 1'b0;
    end else begin
      if (slot_adv_i)    sd_q <= sd_n;
      if (frame_start_i) begin
        l_q <= left_i;
        r_q <= right_i;
      end
    end
  end

  assign sdata_o = sd_q;

  a_r8_hold_between_frames: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((l_q != $past(l_q)) || (r_q != $past(r_q))) |-> $past(frame_start_i));
endmodule

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int HALF_BASE = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rate_sel_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                req_o,
  output logic                mclk_o,
  output logic                sclk_o,
  output logic                lrclk_o,
  output logic                sdata_o
);
  localparam int SLOTS  = 2 * SAMPLE_W;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int PH_W   = $clog2(2 * HALF_BASE);

  logic              slot_adv, frame_start;
  logic [SLOT_W-1:0] slot_n;

  assign mclk_o = clk_i;

  i2s_bitclk #(.HALF_BASE(HALF_BASE), .PH_W(PH_W)) u_bitclk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rate_sel_i   (rate_sel_i),
    .frame_start_i(frame_start),
    .slot_adv_o   (slot_adv),
    .sclk_o       (sclk_o)
  );

  i2s_frame_seq #(.SAMPLE_W(SAMPLE_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_adv_i   (slot_adv),
    .frame_start_o(frame_start),
    .slot_n_o     (slot_n),
    .lrclk_o      (lrclk_o),
    .req_o        (req_o)
  );

  i2s_serializer #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_ser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start),
    .slot_adv_i   (slot_adv),
    .slot_n_i     (slot_n),
    .left_i       (left_i),
    .right_i      (right_i),
    .sdata_o      (sdata_o)
  );

  a_r3_sdata_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  a_r5_lr_on_sclk_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrclk_o) |-> $fell(sclk_o));

  a_r6_req_at_lr_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $fell(lrclk_o));
endmodule

// File: tb/i2s_tx_clkgen_tb.sv
module i2s_tx_clkgen_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rate_sel_i = 1'b0;
  logic [23:0] left_i = 24'hA5C3E1;
  logic [23:0] right_i = 24'h3C5A96;
  logic        req_o, mclk_o, sclk_o, lrclk_o, sdata_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [23:0] cur_l = 24'hA5C3E1, cur_r = 24'h3C5A96;
  logic        cur_rate = 1'b0, prev_r0 = 1'b0;

  always #5 clk = ~clk;

  i2s_tx_clkgen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .rate_sel_i(rate_sel_i),
    .left_i(left_i), .right_i(right_i), .req_o(req_o),
    .mclk_o(mclk_o), .sclk_o(sclk_o), .lrclk_o(lrclk_o), .sdata_o(sdata_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check("R9 sclk in reset", 64'(sclk_o), 64'd1);
    check("R9 lrclk in reset", 64'(lrclk_o), 64'd1);
    check("R9 sdata in reset", 64'(sdata_o), 64'd0);
    check("R9 req in reset", 64'(req_o), 64'd0);
    check("R10 mclk low phase", 64'(mclk_o), 64'd0);
    @(posedge clk); #1;
    check("R10 mclk high phase", 64'(mclk_o), 64'd1);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R9 first frame on first edge", 64'(req_o), 64'd1);
    check("R6 lrclk low at request", 64'(lrclk_o), 64'd0);
  endtask

  // entered at the negedge of a request cycle; captures the frame now running
  task automatic run_frame(input logic [23:0] nl, input logic [23:0] nr,
                           input logic nrate, input int mode);
    int cyc, hi, k, len, hi_exp;
    logic [47:0] bits, lrs, exp_bits;
    logic prev_s;
    left_i = nl;
    right_i = nr;
    if (mode != 2) rate_sel_i = nrate;
    cyc = 1; hi = 0; k = 0; prev_s = sclk_o; bits = '0; lrs = '0;
    forever begin
      @(negedge clk);
      if (cyc == 1) check("R6 request lasts one cycle", 64'(req_o), 64'd0);
      if (req_o) break;
      cyc++;
      if (mode == 1 && cyc == 200) begin left_i = ~nl; right_i = ~nr; end
      if (mode == 1 && cyc == 300) begin left_i = nl; right_i = nr; end
      if (mode == 2 && cyc == 100) rate_sel_i = nrate;
      if (sclk_o) hi++;
      if (sclk_o && !prev_s) begin
        if (k < 48) begin bits[k] = sdata_o; lrs[k] = lrclk_o; end
        k++;
      end
      prev_s = sclk_o;
      if (cyc > 2000) break;
    end
    len = cur_rate ? 384 : 768;
    hi_exp = cur_rate ? 192 : 384;
    exp_bits[0] = prev_r0;
    for (int i = 1; i <= 24; i++) exp_bits[i] = cur_l[24 - i];
    for (int i = 25; i <= 47; i++) exp_bits[i] = cur_r[48 - i];
    check("R1 frame length", 64'(cyc), 64'(len));
    check("R2 sclk periods per frame", 64'(k), 64'd48);
    check("R2 sclk high cycles", 64'(hi), 64'(hi_exp));
    check("R3 left bits msb first", 64'(bits[24:1]), 64'(exp_bits[24:1]));
    check("R4 right bits and lsb in next slot 0",
          64'({bits[47:25], bits[0]}), 64'({exp_bits[47:25], exp_bits[0]}));
    check("R5 lrclk per slot", 64'(lrs), 64'({24'hFFFFFF, 24'h000000}));
    if (mode == 1) check("R8 mid-frame input change ignored", 64'(bits[24:1]), 64'(exp_bits[24:1]));
    if (mode == 2) check("R7 rate change held to frame end", 64'(cyc), 64'(len));
    prev_r0 = cur_r[0];
    cur_l = nl;
    cur_r = nr;
    cur_rate = nrate;
  endtask

  initial begin
    test_reset();
    run_frame(24'hFFFFFF, 24'h000000, 1'b0, 0);
    run_frame(24'h800001, 24'h7FFFFE, 1'b1, 0);
    run_frame(24'h123456, 24'hFEDCBA, 1'b1, 1);
    run_frame(24'h0F0F0F, 24'hF0F0F0, 1'b0, 2);
    run_frame(24'h000001, 24'h800000, 1'b0, 0);
    run_frame(24'h5A5A5A, 24'hA5A5A5, 1'b1, 1);
    run_frame(24'h000000, 24'h000000, 1'b1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule